// File: doc/BRIEF.md
# Complementary Dead-Time Inserter

This block turns each PWM channel waveform into two gate-drive signals. The high-side output follows the waveform and the low-side output follows its inverse. The inverse is named the complementary output here. A programmable gap is opened at every transition so that the two switches of a half bridge are never on together. The outputs are used to drive external power stages. The block is placed directly behind a PWM counter that produces the raw waveforms.

All channels share one low-side gap count and one high-side gap count, both 8 bits wide. Each channel has its own insertion enable. Time is measured in ticks of a clock-enable input, so the gap scales with whatever prescaled timer rate the counter uses. When a waveform changes, the output that must turn off does so at once. The output that must turn on waits the programmed number of ticks. If the waveform changes back during that wait, the pending turn-on is abandoned.

Top module: `cmpl_deadtime`

## Requirements
- R1: On no channel are the high-side and low-side outputs both 1 in the same cycle, whatever the enables, gap counts or input pattern.
- R2: On a channel whose insertion enable is 0, each tick copies the waveform to the high-side output and its inverse to the low-side output, visible one clock after that tick, with no gap.
- R3: On an enabled channel, a rising waveform sampled on tick k clears the low-side output at tick k. The high-side output rises at tick k+H, where H is the high-side gap count.
- R4: On an enabled channel, a falling waveform sampled on tick k clears the high-side output at tick k. The low-side output rises at tick k+L, where L is the low-side gap count.
- R5: A gap count of 0 swaps the two outputs on the very tick the edge is sampled, with no interval where both are 0.
- R6: If the waveform reverts before a pending turn-on is due, that turn-on never happens. The other output then follows the rule for the new edge.
- R7: Without a tick, neither output changes and pending gaps do not advance. Only ticked clocks are counted toward a gap.
- R8: The gap counts are shared by all channels, and the insertion enables act per channel. A disabled channel switches at once while an enabled channel with the same edge waits its gap.
- R9: Reset drives both outputs of every channel to 0. The first tick after reset treats the sampled level as a fresh edge, so a low waveform brings the low-side output on L ticks later.
- R10: The gap length is the value of the count input on the tick the edge is sampled. Changing the count input during a gap does not shorten or lengthen it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable; one timer step per cycle where it is 1 |
| pwm_in | input | NUM_CH | Raw PWM waveform, one bit per channel |
| dt_low | input | DT_W | Shared low-side turn-on gap, in ticks |
| dt_high | input | DT_W | Shared high-side turn-on gap, in ticks (forced to 0 when HS_DT_EN is 0) |
| ins_en | input | NUM_CH | Per-channel gap insertion enable |
| hs_out | output | NUM_CH | High-side drive, 1 = on |
| ls_out | output | NUM_CH | Low-side drive, 1 = on |

## Verification
The hardest situation to reach from the ports is a waveform reversal that lands inside a running gap. In that case a turn-on has been armed but must be dropped without ever showing on the output. The stimulus programs a long high-side gap and raises a waveform. It lowers the waveform again three ticks later. Over the following window it confirms that the high side never rises and that the low side returns exactly after the low-side gap. A second hard case is the gap count changing while a gap is running. To cover it, the bench rewrites both count inputs in the middle of a gap and measures the turn-on delay against the count captured at the edge.

// File: rtl/cmpl_dt_pkg.sv
package cmpl_dt_pkg;

   // Which output, if any, is waiting for its gap to run out
   typedef enum logic [1:0] {
      ARM_NONE = 2'd0,
      ARM_HIGH = 2'd1,
      ARM_LOW  = 2'd2
   } arm_e;

   localparam int unsigned DT_W_MAX = 16;

endpackage

// File: rtl/cmpl_dt_sampler.sv
module cmpl_dt_sampler #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [NUM_CH-1:0] wave_in,
   output logic [NUM_CH-1:0] chg_o
);

   logic [NUM_CH-1:0] prev_q;
   logic              primed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else if (tick) begin
         prev_q   <= wave_in;
         primed_q <= 1'b1;
      end
   end

   // A change is seen only on a tick; the first tick after reset counts as one
   assign chg_o = {NUM_CH{tick}} & ({NUM_CH{~primed_q}} | (wave_in ^ prev_q));

endmodule

// File: rtl/cmpl_dt_timer.sv
module cmpl_dt_timer #(
   parameter int unsigned DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clear,
   input  logic            load,
   input  logic [DT_W-1:0] load_val,
   output logic            expire_o
);

   localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

   logic [DT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (clear)
            cnt_q <= '0;
         else if (load)
            cnt_q <= load_val;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - ONE;
      end
   end

   assign expire_o = tick && !clear && !load && (cnt_q == ONE);

   // R7: the count only moves on ticks
   p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

endmodule

// File: rtl/cmpl_dt_lane.sv
module cmpl_dt_lane
   import cmpl_dt_pkg::*;
#(
   parameter int unsigned DT_W     = 8,
   parameter bit          HS_DT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            lvl,
   input  logic            chg,
   input  logic            ins_en,
   input  logic [DT_W-1:0] dt_lo,
   input  logic [DT_W-1:0] dt_hi,
   output logic            hs_o,
   output logic            ls_o
);

   logic [DT_W-1:0] hi_eff;
   logic [DT_W-1:0] gap_val;
   logic            arm_load;
   logic            expire;
   logic            hs_q, ls_q;
   arm_e            arm_q;

   generate
      if (HS_DT_EN) begin : g_hs_gap
         assign hi_eff = dt_hi;
      end else begin : g_hs_nogap
         assign hi_eff = dt_hi & {DT_W{1'b0}};
      end
   endgenerate

   assign gap_val  = lvl ? hi_eff : dt_lo;
   assign arm_load = chg && ins_en;

   cmpl_dt_timer #(.DT_W(DT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clear    (!ins_en),
      .load     (arm_load),
      .load_val (gap_val),
      .expire_o (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q  <= 1'b0;
         ls_q  <= 1'b0;
         arm_q <= ARM_NONE;
      end else if (tick) begin
         if (!ins_en) begin
            hs_q  <= lvl;
            ls_q  <= !lvl;
            arm_q <= ARM_NONE;
         end else if (chg) begin
            if (lvl) begin
               ls_q <= 1'b0;
               hs_q <= (gap_val == '0);
            end else begin
               hs_q <= 1'b0;
               ls_q <= (gap_val == '0);
            end
            if (gap_val == '0)
               arm_q <= ARM_NONE;
            else
               arm_q <= lvl ? ARM_HIGH : ARM_LOW;
         end else if (expire) begin
            if (arm_q == ARM_HIGH) hs_q <= 1'b1;
            if (arm_q == ARM_LOW)  ls_q <= 1'b1;
            arm_q <= ARM_NONE;
         end
      end
   end

   assign hs_o = hs_q;
   assign ls_o = ls_q;

   p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_q && ls_q));

   p_plain_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !ins_en |=> (hs_q == $past(lvl)) && (ls_q != $past(lvl)));

   p_ls_off_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && ins_en && chg && lvl |=> !ls_q);

   p_hs_off_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick && ins_en && chg && !lvl |=> !hs_q);

   p_zero_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick && ins_en && chg && lvl && (hi_eff == '0) |=> hs_q);

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(hs_q) && $stable(ls_q));

endmodule

// File: rtl/cmpl_deadtime.sv
module cmpl_deadtime
   import cmpl_dt_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned DT_W     = 8,
   parameter bit          HS_DT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [NUM_CH-1:0] pwm_in,
   input  logic [DT_W-1:0]   dt_low,
   input  logic [DT_W-1:0]   dt_high,
   input  logic [NUM_CH-1:0] ins_en,
   output logic [NUM_CH-1:0] hs_out,
   output logic [NUM_CH-1:0] ls_out
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("cmpl_deadtime: NUM_CH must be at least 1");
      end
      if (DT_W < 1 || DT_W > DT_W_MAX) begin : g_bad_w
         $error("cmpl_deadtime: DT_W out of range");
      end
   endgenerate

   logic [NUM_CH-1:0] chg;

   cmpl_dt_sampler #(.NUM_CH(NUM_CH)) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wave_in (pwm_in),
      .chg_o   (chg)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
         cmpl_dt_lane #(.DT_W(DT_W), .HS_DT_EN(HS_DT_EN)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .lvl    (pwm_in[c]),
            .chg    (chg[c]),
            .ins_en (ins_en[c]),
            .dt_lo  (dt_low),
            .dt_hi  (dt_high),
            .hs_o   (hs_out[c]),
            .ls_o   (ls_out[c])
         );
      end
   endgenerate

endmodule

// File: tb/cmpl_deadtime_test.sv
module cmpl_deadtime_test;

   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           tick;
   logic [NCH-1:0] pwm;
   logic [7:0]     dt_lo, dt_hi;
   logic [NCH-1:0] ins_en;
   logic [NCH-1:0] hs, ls;

   int checks = 0;
   int errors = 0;
   int overlap = 0;

   always #4 clk = ~clk;

   cmpl_deadtime #(.NUM_CH(NCH), .DT_W(8), .HS_DT_EN(1'b1)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .pwm_in  (pwm),
      .dt_low  (dt_lo),
      .dt_high (dt_hi),
      .ins_en  (ins_en),
      .hs_out  (hs),
      .ls_out  (ls)
   );

   always @(negedge clk) if (rst_n === 1'b1 && (hs & ls) != '0) overlap++;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Drive an edge on channel ch, then find the sample index where the
   // turning-on output rises (index 0 = just after the tick that sees the edge)
   task automatic measure(input int ch, input bit rise, input int d, input string req,
                          input int mod_at, input logic [7:0] mod_val);
      int first = -1;
      pwm[ch] = rise;
      for (int i = 0; i < 300 && first < 0; i++) begin
         step();
         if (i == 0)
            chk((rise ? ls[ch] : hs[ch]) == 1'b0, req, "trailing edge not immediate",
                int'(rise ? ls[ch] : hs[ch]), 0);
         if ((rise ? hs[ch] : ls[ch]) == 1'b1) first = i;
         if (i == mod_at) begin
            dt_lo = mod_val;
            dt_hi = mod_val;
         end
      end
      chk(first == d, req, "turn-on delay in ticks", first, d);
   endtask

   task automatic tick_pulse();
      tick = 1'b1;
      step();
      tick = 1'b0;
      step();
      step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int first;
      int hs_seen;
      logic [15:0] pat;

      // R9: reset state and first tick after reset
      rst_n  = 1'b0;
      tick   = 1'b1;
      pwm    = '0;
      dt_lo  = 8'd3;
      dt_hi  = 8'd3;
      ins_en = '1;
      repeat (4) step();
      chk(hs == '0, "R9", "hs during reset", int'(hs), 0);
      chk(ls == '0, "R9", "ls during reset", int'(ls), 0);
      rst_n = 1'b1;
      first = -1;
      for (int i = 0; i < 20 && first < 0; i++) begin
         step();
         if (ls[0]) first = i;
      end
      chk(first == 3, "R9", "first low-side turn-on after reset", first, 3);
      chk(ls == '1, "R9", "all low sides on after reset", int'(ls), 15);
      chk(hs == '0, "R9", "high sides off after reset", int'(hs), 0);

      // R3, R4, R5: sweep the gap count on the first and last channel
      for (int k = 0; k < 2; k++) begin
         int ch = (k == 0) ? 0 : NCH - 1;
         for (int d = 0; d <= 14; d++) begin
            dt_lo = 8'(d);
            dt_hi = 8'(d);
            measure(ch, 1'b1, d, (d == 0) ? "R5" : "R3", -1, 8'd0);
            measure(ch, 1'b0, d, (d == 0) ? "R5" : "R4", -1, 8'd0);
         end
         dt_lo = 8'd255;
         dt_hi = 8'd255;
         measure(ch, 1'b1, 255, "R3", -1, 8'd0);
         measure(ch, 1'b0, 255, "R4", -1, 8'd0);
      end
      // asymmetric counts
      dt_lo = 8'd2;
      dt_hi = 8'd7;
      measure(1, 1'b1, 7, "R3", -1, 8'd0);
      dt_lo = 8'd2;
      dt_hi = 8'd7;
      measure(1, 1'b0, 2, "R4", -1, 8'd0);

      // R10: count captured at the edge
      dt_lo = 8'd8;
      dt_hi = 8'd8;
      measure(0, 1'b1, 8, "R10", 2, 8'd1);
      dt_lo = 8'd9;
      dt_hi = 8'd9;
      measure(0, 1'b0, 9, "R10", 1, 8'd40);

      // R6: reversal inside a running high-side gap
      dt_hi = 8'd10;
      dt_lo = 8'd2;
      pwm[0] = 1'b1;
      repeat (3) step();
      pwm[0] = 1'b0;
      first = -1;
      hs_seen = 0;
      for (int i = 0; i < 40; i++) begin
         step();
         if (hs[0]) hs_seen++;
         if (ls[0] && first < 0) first = i;
      end
      chk(hs_seen == 0, "R6", "cancelled high side rose", hs_seen, 0);
      chk(first == 2, "R6", "low side return after reversal", first, 2);

      // R7: tick gating
      dt_hi = 8'd2;
      tick = 1'b0;
      pwm[0] = 1'b1;
      repeat (5) step();
      chk(ls[0] == 1'b1, "R7", "ls moved without tick", int'(ls[0]), 1);
      chk(hs[0] == 1'b0, "R7", "hs moved without tick", int'(hs[0]), 0);
      tick_pulse();
      chk(ls[0] == 1'b0, "R7", "ls after tick 1", int'(ls[0]), 0);
      chk(hs[0] == 1'b0, "R7", "hs after tick 1", int'(hs[0]), 0);
      tick_pulse();
      chk(hs[0] == 1'b0, "R7", "hs after tick 2", int'(hs[0]), 0);
      tick_pulse();
      chk(hs[0] == 1'b1, "R7", "hs after tick 3", int'(hs[0]), 1);
      tick = 1'b1;
      pwm[0] = 1'b0;
      dt_lo = 8'd0;
      repeat (3) step();

      // R8: shared counts, per-channel enable
      ins_en = 4'b1101;
      dt_lo = 8'd5;
      dt_hi = 8'd5;
      step();
      pwm[1:0] = 2'b11;
      first = -1;
      for (int i = 0; i < 12 && first < 0; i++) begin
         step();
         if (i == 0) begin
            chk(hs[1] == 1'b1, "R8", "disabled channel high side", int'(hs[1]), 1);
            chk(ls[1] == 1'b0, "R8", "disabled channel low side", int'(ls[1]), 0);
         end
         if (hs[0]) first = i;
      end
      chk(first == 5, "R8", "enabled channel gap", first, 5);
      pwm[1:0] = 2'b00;
      repeat (10) step();

      // R2: plain complement on a disabled channel, gap counts ignored
      pat = 16'hB38D;
      for (int i = 0; i < 16; i++) begin
         pwm[1] = pat[i];
         step();
         chk(hs[1] == pat[i], "R2", "plain high side", int'(hs[1]), int'(pat[i]));
         chk(ls[1] == !pat[i], "R2", "plain low side", int'(ls[1]), int'(!pat[i]));
      end

      // R1: no overlap anywhere in the run
      chk(overlap == 0, "R1", "cycles with both outputs on", overlap, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule